// File: doc/BRIEF.md
# Dual-Port RAM with Deterministic Collision Handling

This block is a single-clock memory with two fully independent ports, A and B. Each port can read or write on any cycle. Each port returns its read data through its own output register, one cycle after the access. Both ports have the same data width. Each port is given a fixed read-during-write behaviour when the block is built. In read-first mode the port returns the old contents while it writes. In write-first mode it returns the data it just wrote. In no-change mode its output register holds its value during a write.

When both ports touch the same address in the same cycle, the result is fixed rather than left to chance. Two reads both return the stored word. Two writes are settled in favour of port A: port B's write is discarded, and an optional flag pulses for one cycle. When one port writes an address that the other port reads, the reading port gets the contents as they were before that write. This lets a system use both ports freely and get the same behaviour in simulation and in hardware.

Top module: `tdp_coll_ram`

## Requirements
- R1: A word written through either port is stored, and an enabled read of that address on either port shows it on that port's read data output one clock later.
- R2: A port in read-first mode (mode code 0) that writes shows the address's previous contents on its read output one clock later.
- R3: A port in write-first mode (mode code 1) that writes shows the word that ends up stored at that address on its read output one clock later.
- R4: A port in no-change mode (mode code 2) that writes keeps its read output unchanged.
- R5: A port whose enable is low neither reads nor writes, even with its write enable high, and its read output keeps its value.
- R6: Two enabled reads of the same address in one cycle both return the stored word.
- R7: When both ports write the same address in one cycle, port A's data is stored and port B's write is discarded.
- R8: With the flag enabled, coll_o is high for exactly the one cycle after a same-address double write, and low after every other cycle.
- R9: When one port writes an address in the cycle the other port reads it, the reading port returns the contents from before that write.
- R10: A write-first port B whose write loses to port A returns port A's write data.
- R11: While rst_ni is low, both read outputs and coll_o are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Common clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| a_en_i | input | 1 | Port A access enable |
| a_we_i | input | 1 | Port A write enable |
| a_addr_i | input | AW | Port A address |
| a_wdata_i | input | DW | Port A write data |
| a_rdata_o | output | DW | Port A registered read data |
| b_en_i | input | 1 | Port B access enable |
| b_we_i | input | 1 | Port B write enable |
| b_addr_i | input | AW | Port B address |
| b_wdata_i | input | DW | Port B write data |
| b_rdata_o | output | DW | Port B registered read data |
| coll_o | output | 1 | Pulse after a same-address double write |

## Verification
In a single cycle, a port's own read-during-write behaviour can coincide with a cross-port collision on the same address. Port B may write-first while port A overwrites the same word, or one port may write an address while the other reads it. The bench forces these cases by driving both ports to equal addresses with every mix of enable and write enable. It does this in directed steps and then in a random burst confined to 16 addresses. Two instances receive the same stimulus, one with A read-first and B write-first and one with A no-change and B read-first. A reference model predicts all four read outputs and the flag for each cycle, and a scoreboard compares them.

// File: rtl/tdp_pkg.sv
package tdp_pkg;
  typedef enum logic [1:0] {
    RDW_READ_FIRST  = 2'd0,
    RDW_WRITE_FIRST = 2'd1,
    RDW_NO_CHANGE   = 2'd2
  } rdw_mode_e;
endpackage

// File: rtl/tdp_collide.sv
module tdp_collide #(
  parameter int unsigned AW      = 11,
  parameter bit          COLL_EN = 1'b1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          a_en_i,
  input  logic          a_we_i,
  input  logic [AW-1:0] a_addr_i,
  input  logic          b_en_i,
  input  logic          b_we_i,
  input  logic [AW-1:0] b_addr_i,
  output logic          a_wr_o,
  output logic          b_wr_o,
  output logic          b_lost_o,
  output logic          coll_o
);
  logic same_addr, b_req;

  assign same_addr = (a_addr_i == b_addr_i);
  assign a_wr_o    = a_en_i & a_we_i;
  assign b_req     = b_en_i & b_we_i;
  assign b_lost_o  = a_wr_o & b_req & same_addr;  // static priority: A wins
  assign b_wr_o    = b_req & ~b_lost_o;

  generate
    if (COLL_EN) begin : g_flag
      logic coll_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) coll_q <= 1'b0;
        else         coll_q <= b_lost_o;
      end
      assign coll_o = coll_q;

      a_r8_coll_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (a_en_i && a_we_i && b_en_i && b_we_i && a_addr_i == b_addr_i) |=> coll_o);
      a_r8_coll_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(a_en_i && a_we_i && b_en_i && b_we_i && a_addr_i == b_addr_i) |=> !coll_o);
    end else begin : g_noflag
      assign coll_o = 1'b0;
    end
  endgenerate

  a_r7_single_writer: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (a_wr_o && b_wr_o) |-> (a_addr_i != b_addr_i));
endmodule

// File: rtl/tdp_port_reg.sv
module tdp_port_reg
  import tdp_pkg::*;
#(
  parameter int unsigned DW   = 9,
  parameter rdw_mode_e   MODE = RDW_READ_FIRST
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          we_i,
  input  logic [DW-1:0] old_i,    // array contents before this cycle's writes
  input  logic [DW-1:0] new_i,    // word stored at this address by this cycle
  output logic [DW-1:0] rd_o
);
  localparam bit HOLD_ON_WR = (MODE == RDW_NO_CHANGE);
  localparam bit NEW_ON_WR  = (MODE == RDW_WRITE_FIRST);

  logic          load;
  logic [DW-1:0] sel, rd_q;

  assign load = en_i & ~(we_i & HOLD_ON_WR);
  assign sel  = (we_i && NEW_ON_WR) ? new_i : old_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rd_q <= '0;
    else if (load) rd_q <= sel;
  end
  assign rd_o = rd_q;

  a_r5_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(rd_o));

  generate
    if (HOLD_ON_WR) begin : g_nc_chk
      a_r4_nc_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (en_i && we_i) |=> $stable(rd_o));
    end
  endgenerate
endmodule

// File: rtl/tdp_coll_ram.sv
module tdp_coll_ram
  import tdp_pkg::*;
#(
  parameter int unsigned DW      = 9,
  parameter int unsigned AW      = 11,
  parameter rdw_mode_e   MODE_A  = RDW_READ_FIRST,
  parameter rdw_mode_e   MODE_B  = RDW_WRITE_FIRST,
  parameter bit          COLL_EN = 1'b1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          a_en_i,
  input  logic          a_we_i,
  input  logic [AW-1:0] a_addr_i,
  input  logic [DW-1:0] a_wdata_i,
  output logic [DW-1:0] a_rdata_o,
  input  logic          b_en_i,
  input  logic          b_we_i,
  input  logic [AW-1:0] b_addr_i,
  input  logic [DW-1:0] b_wdata_i,
  output logic [DW-1:0] b_rdata_o,
  output logic          coll_o
);
  localparam int unsigned DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];
  logic          a_wr, b_wr, b_lost;
  logic [DW-1:0] a_old, b_old, b_new;

  tdp_collide #(.AW(AW), .COLL_EN(COLL_EN)) i_collide (
    .clk_i, .rst_ni,
    .a_en_i, .a_we_i, .a_addr_i,
    .b_en_i, .b_we_i, .b_addr_i,
    .a_wr_o   (a_wr),
    .b_wr_o   (b_wr),
    .b_lost_o (b_lost),
    .coll_o
  );

  always_ff @(posedge clk_i) begin
    if (a_wr) mem[a_addr_i] <= a_wdata_i;
    if (b_wr) mem[b_addr_i] <= b_wdata_i;
  end

  assign a_old = mem[a_addr_i];
  assign b_old = mem[b_addr_i];
  assign b_new = b_lost ? a_wdata_i : b_wdata_i;  // what B's address ends up holding

  tdp_port_reg #(.DW(DW), .MODE(MODE_A)) i_port_a (
    .clk_i, .rst_ni,
    .en_i  (a_en_i),
    .we_i  (a_we_i),
    .old_i (a_old),
    .new_i (a_wdata_i),
    .rd_o  (a_rdata_o)
  );

  tdp_port_reg #(.DW(DW), .MODE(MODE_B)) i_port_b (
    .clk_i, .rst_ni,
    .en_i  (b_en_i),
    .we_i  (b_we_i),
    .old_i (b_old),
    .new_i (b_new),
    .rd_o  (b_rdata_o)
  );

  a_r7_a_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (a_en_i && a_we_i && b_en_i && b_we_i && a_addr_i == b_addr_i)
    |=> mem[$past(a_addr_i)] == $past(a_wdata_i));

  a_r9_b_reads_old: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (a_en_i && a_we_i && b_en_i && !b_we_i && a_addr_i == b_addr_i)
    |=> b_rdata_o == $past(b_old));

  a_r9_a_reads_old: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (b_en_i && b_we_i && a_en_i && !a_we_i && a_addr_i == b_addr_i)
    |=> a_rdata_o == $past(a_old));
endmodule

// File: tb/test_tdp_coll_ram.sv
`timescale 1ns/1ps
module test_tdp_coll_ram;
  import tdp_pkg::*;
  localparam int DW = 9;
  localparam int AW = 11;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic a_en = 0, a_we = 0, b_en = 0, b_we = 0;
  logic [AW-1:0] a_addr = '0, b_addr = '0;
  logic [DW-1:0] a_wd = '0, b_wd = '0;
  logic [DW-1:0] a_rd, b_rd, na_rd, nb_rd;
  logic coll, ncoll;

  always #2.5 clk = ~clk;

  // A read-first, B write-first
  tdp_coll_ram #(.DW(DW), .AW(AW), .MODE_A(RDW_READ_FIRST), .MODE_B(RDW_WRITE_FIRST)) i_tdp_coll_ram (
    .clk_i(clk), .rst_ni(rst_n),
    .a_en_i(a_en), .a_we_i(a_we), .a_addr_i(a_addr), .a_wdata_i(a_wd), .a_rdata_o(a_rd),
    .b_en_i(b_en), .b_we_i(b_we), .b_addr_i(b_addr), .b_wdata_i(b_wd), .b_rdata_o(b_rd),
    .coll_o(coll));

  // A no-change, B read-first
  tdp_coll_ram #(.DW(DW), .AW(AW), .MODE_A(RDW_NO_CHANGE), .MODE_B(RDW_READ_FIRST)) i_tdp_coll_ram_nc (
    .clk_i(clk), .rst_ni(rst_n),
    .a_en_i(a_en), .a_we_i(a_we), .a_addr_i(a_addr), .a_wdata_i(a_wd), .a_rdata_o(na_rd),
    .b_en_i(b_en), .b_we_i(b_we), .b_addr_i(b_addr), .b_wdata_i(b_wd), .b_rdata_o(nb_rd),
    .coll_o(ncoll));

  typedef struct {
    logic [DW-1:0] a, b, na, nb;
    bit va, vb, vna, vnb;
    bit coll;
    string tag;
  } exp_t;

  exp_t q[$];
  int n_chk = 0, n_bad = 0;

  logic [DW-1:0] m [DEPTH];
  bit mv [DEPTH];
  logic [DW-1:0] ha = '0, hb = '0, hna = '0, hnb = '0;
  bit hva = 1, hvb = 1, hvna = 1, hvnb = 1;

  task automatic chk(string tag, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic cyc(bit ea, bit wa, int aa, logic [DW-1:0] da,
                     bit eb, bit wb, int ab, logic [DW-1:0] db, string tag);
    exp_t e;
    logic [DW-1:0] oa, ob;
    bit ova, ovb, wra, reqb, lost, wrb;
    @(negedge clk);
    a_en = ea; a_we = wa; a_addr = AW'(aa); a_wd = da;
    b_en = eb; b_we = wb; b_addr = AW'(ab); b_wd = db;
    oa = m[aa]; ova = mv[aa]; ob = m[ab]; ovb = mv[ab];
    wra = ea && wa; reqb = eb && wb;
    lost = wra && reqb && (aa == ab);
    wrb = reqb && !lost;
    if (ea) begin ha = oa; hva = ova; end
    if (eb) begin
      if (wb) begin hb = lost ? da : db; hvb = 1; end
      else begin hb = ob; hvb = ovb; end
    end
    if (ea && !wa) begin hna = oa; hvna = ova; end
    if (eb) begin hnb = ob; hvnb = ovb; end
    if (wra) begin m[aa] = da; mv[aa] = 1; end
    if (wrb) begin m[ab] = db; mv[ab] = 1; end
    e.a = ha; e.b = hb; e.na = hna; e.nb = hnb;
    e.va = hva; e.vb = hvb; e.vna = hvna; e.vnb = hvnb;
    e.coll = lost; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic idle(string tag);
    cyc(0, 0, 0, '0, 0, 0, 0, '0, tag);
  endtask

  // monitor: pops one prediction per clock, samples 1 ns after the edge
  initial begin
    exp_t e;
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        e = q.pop_front();
        if (e.va)  chk(e.tag, "a_rd",  a_rd,  e.a);
        if (e.vb)  chk(e.tag, "b_rd",  b_rd,  e.b);
        if (e.vna) chk(e.tag, "na_rd", na_rd, e.na);
        if (e.vnb) chk(e.tag, "nb_rd", nb_rd, e.nb);
        chk(e.tag, "coll",  {{(DW-1){1'b0}}, coll},  {{(DW-1){1'b0}}, e.coll});
        chk(e.tag, "ncoll", {{(DW-1){1'b0}}, ncoll}, {{(DW-1){1'b0}}, e.coll});
      end
    end
  end

  initial begin
    #200_000;
    n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) begin m[i] = '0; mv[i] = 0; end
    repeat (3) @(negedge clk);
    // R11: reset state
    chk("R11", "a_rd", a_rd, '0);
    chk("R11", "b_rd", b_rd, '0);
    chk("R11", "na_rd", na_rd, '0);
    chk("R11", "nb_rd", nb_rd, '0);
    chk("R11", "coll", {{(DW-1){1'b0}}, coll}, '0);
    rst_n = 1'b1;

    // R1/R3: fill through B (write-first), A idle holds (R5)
    for (int i = 0; i < 8; i++) cyc(0, 0, 0, '0, 1, 1, i, DW'(9'h040 + i*3), "R1_R3_R5");
    // R6: same-address double read
    cyc(1, 0, 3, '0, 1, 0, 3, '0, "R6");
    cyc(1, 0, 7, '0, 1, 0, 7, '0, "R6");
    // R2 / R4: A writes addr 2 (read-first shows old, no-change holds)
    cyc(1, 1, 2, 9'h1c5, 0, 0, 0, '0, "R2_R4");
    cyc(1, 0, 2, '0, 1, 0, 2, '0, "R1");
    // R5: A disabled with write enable high must not write
    cyc(0, 1, 4, 9'h0ff, 1, 1, 4, 9'h123, "R5");
    cyc(1, 0, 4, '0, 0, 1, 4, 9'h0ee, "R5");
    cyc(1, 0, 4, '0, 1, 0, 4, '0, "R5");
    // R7/R8/R10: double write, A wins, flag pulses, B write-first shows A data
    cyc(1, 1, 6, 9'h055, 1, 1, 6, 9'h1aa, "R7_R8_R10");
    idle("R8");
    cyc(1, 0, 6, '0, 1, 0, 6, '0, "R7");
    // R9: cross-port write while other port reads
    cyc(1, 1, 1, 9'h13c, 1, 0, 1, '0, "R9");
    cyc(1, 0, 0, '0, 1, 1, 0, 9'h0a7, "R9");
    cyc(1, 0, 1, '0, 1, 0, 0, '0, "R9");
    // R8: both write different addresses, no flag
    cyc(1, 1, 10, 9'h111, 1, 1, 11, 9'h022, "R8");
    cyc(1, 0, 11, '0, 1, 0, 10, '0, "R1");
    // random burst over a small window of addresses
    for (int k = 0; k < 400; k++) begin
      automatic int r = $urandom;
      cyc(r[0], r[1], (r >> 4) & 15, DW'(r >> 12),
          r[2], r[3], (r >> 8) & 15, DW'(r >> 21), "R1_R7_R9");
    end
    idle("R5");
    idle("R5");
    @(negedge clk);
    @(negedge clk);
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule